// File: doc/BRIEF.md
# Dual-Mode Serial Register Port

This block is a serial slave. Through it a host reaches a 128-location space of clock registers and RAM that lies outside the block. A static mode input picks one of two framings. In four-wire SPI framing there is a separate input line and a separate output line, and bits travel most significant first. In three-wire framing one shared line carries data both ways, and bits travel least significant first. The shared line is wired so that the block reads it on `ser_din` and drives it through `ser_dout` whenever `ser_dout_en` is high.

A transaction starts when the chip enable rises. The first byte is an address byte, and its top bit selects the direction. After it come any number of data bytes. The location pointer steps after every byte and wraps inside its own region. All serial inputs are synchronised into the system clock, and their edges are detected there. The block keeps its own copy of the write-protect bit. It exposes a one-cycle write strobe with a bit mask, and a one-cycle read strobe that expects combinational read data in the same cycle.

The controller has four states. IDLE goes to ADDR when the chip enable rises. ADDR goes to WRITE or READ when the address byte completes, depending on its top bit. WRITE and READ hold until the chip enable falls. From any state, a chip enable that is low returns the controller to IDLE.

Top module: `dual_serial_regport`

## Requirements
- R1: The first byte after chip enable rises is the address. If its bit 7 is 1 the transaction writes; if it is 0 the transaction reads. `reg_addr` carries the address with bit 7 removed.
- R2: With `wire3_mode`=0, address and data bits are taken from `ser_din` and returned on `ser_dout` most significant bit first.
- R3: With `wire3_mode`=1, bits travel least significant bit first. Input is sampled on SCLK rising edges, output changes after SCLK falling edges, and `ser_din` serves as the shared line.
- R4: In SPI framing the SCLK level seen when chip enable rises is taken as the idle level. With a low idle level, input is sampled on rising edges and output changes on falling edges. With a high idle level, input is sampled on falling edges and output changes on rising edges.
- R5: Every data byte advances the pointer. The wraps are 1Fh to 00h and 7Fh to 20h on reads, and 9Fh to 80h and FFh to A0h on writes.
- R6: `ser_dout_en` is 0 while chip enable is low, throughout write transactions, and during the address byte of a read. It is 1 while the read data bits shift out.
- R7: The write-protect bit is bit 6 of the control location (0Fh, written through 8Fh) and is 1 after reset. While it is 1, no write strobe is issued for any other location. A write to the control location then issues a strobe with `reg_wmask`=40h, so only that bit changes. Unprotected writes carry `reg_wmask`=FFh.
- R8: Locations 12h–1Fh are reserved. Reads of them return 00h with no read strobe, and writes to them issue no write strobe.
- R9: If chip enable falls during a partial byte, that byte is discarded and no strobe is issued for it.
- R10: `reg_wr_en` and `reg_rd_en` are single-cycle pulses. During the pulse, `reg_addr` (and `reg_wdata` and `reg_wmask` for a write) hold the location and data of that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wire3_mode | input | 1 | 1 selects three-wire framing, 0 selects SPI |
| ser_cs | input | 1 | Serial chip enable, active high |
| ser_sck | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data in (the shared line in three-wire framing) |
| ser_dout | output | 1 | Serial data out |
| ser_dout_en | output | 1 | Output enable for ser_dout (0 means high impedance) |
| reg_addr | output | 7 | Location being accessed |
| reg_wr_en | output | 1 | Write strobe |
| reg_wdata | output | 8 | Write data |
| reg_wmask | output | 8 | Bit mask for the write |
| reg_rd_en | output | 1 | Read strobe |
| reg_rdata | input | 8 | Read data, valid in the cycle of the read strobe |

## Verification
The case hardest to reach from the ports is the boundary at a region's end. There the pointer must wrap in the middle of a burst while the next byte is already being fetched or committed. It is reached by opening bursts one or two locations before each region's end, in both directions. Each of these bursts is repeated under SPI framing with each idle level and under three-wire framing. The write-protect path is reached before protection is ever cleared, because the protect bit comes out of reset set. A chip-enable drop is placed four bits into a byte so that the discarded-byte path runs.

// File: rtl/srif_pkg.sv
package srif_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WRITE,
        ST_READ
    } srif_state_e;
endpackage

// File: rtl/srif_sync.sv
module srif_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/srif_rx_shift.sv
module srif_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         sample,
    input  logic         lsb_first,
    input  logic         din,
    output logic [W-1:0] data,
    output logic         done
);
    localparam int CW = $clog2(W);
    logic [CW-1:0] cnt;
    logic [W-1:0]  sh, nxt;

    always_comb nxt = lsb_first ? {din, sh[W-1:1]} : {sh[W-2:0], din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sh   <= '0;
            data <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clear) begin
                cnt <= '0;
            end else if (sample) begin
                sh <= nxt;
                if (cnt == CW'(W-1)) begin
                    cnt  <= '0;
                    data <= nxt;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R9: a byte completes only as a single pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/srif_tx_shift.sv
module srif_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift,
    input  logic         lsb_first,
    output logic         bit_out,
    output logic         last
);
    localparam int CW = $clog2(W);
    logic [CW-1:0] cnt, idx;
    logic [W-1:0]  hold;

    always_comb idx = lsb_first ? cnt : CW'(W-1) - cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            hold    <= '0;
            bit_out <= 1'b0;
            last    <= 1'b0;
        end else begin
            last <= 1'b0;
            if (load) hold <= load_data;
            if (clear) begin
                cnt     <= '0;
                bit_out <= 1'b0;
            end else if (shift) begin
                bit_out <= hold[idx];
                if (cnt == CW'(W-1)) begin
                    cnt  <= '0;
                    last <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R5: end of byte is a single pulse
    p_last_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !last);
endmodule

// File: rtl/dual_serial_regport.sv
module dual_serial_regport #(
    parameter int         DATA_W      = 8,
    parameter int         ADDR_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] CLK_TOP     = 7'h1F,
    parameter logic [6:0] RAM_BASE    = 7'h20,
    parameter logic [6:0] CTRL_LOC    = 7'h0F,
    parameter logic [6:0] RSV_LO      = 7'h12,
    parameter logic [6:0] RSV_HI      = 7'h1F,
    parameter int         WP_BIT      = 6,
    parameter logic       WP_RESET    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wire3_mode,
    input  logic              ser_cs,
    input  logic              ser_sck,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              ser_dout_en,
    output logic [ADDR_W-2:0] reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_wmask,
    output logic              reg_rd_en,
    input  logic [DATA_W-1:0] reg_rdata
);
    import srif_pkg::*;

    localparam int LOC_W = ADDR_W - 1;
    localparam logic [LOC_W-1:0]  LOC_MAX  = {LOC_W{1'b1}};
    localparam logic [DATA_W-1:0] MASK_ALL = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] MASK_WP  = DATA_W'(1) << WP_BIT;

    // ---------------- input synchronisation and edges ----------------
    logic [2:0] raw_in, syn_in;
    logic       cs_lvl, sck_lvl, din_lvl, cs_prev, sck_prev;
    logic       cs_rise, sck_rise, sck_fall;

    assign raw_in = {ser_din, ser_sck, ser_cs};

    srif_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
    );

    assign {din_lvl, sck_lvl, cs_lvl} = syn_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev  <= 1'b0;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_lvl;
            sck_prev <= sck_lvl;
        end
    end

    assign cs_rise  = cs_lvl & ~cs_prev;
    assign sck_rise = sck_lvl & ~sck_prev;
    assign sck_fall = ~sck_lvl & sck_prev;

    // ---------------- state ----------------
    srif_state_e       state_q, state_d;
    logic              cpol_q, wp_q, dout_en_q;
    logic              inc_pend_q, fetch_pend_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              strobe_ev, shift_ev;
    logic              rx_done, tx_last, tx_bit;
    logic [DATA_W-1:0] rx_data;
    logic              ptr_rsv, ptr_ctrl;

    assign strobe_ev = cpol_q ? sck_fall : sck_rise;
    assign shift_ev  = cpol_q ? sck_rise : sck_fall;
    assign ptr_rsv   = (ptr_q[LOC_W-1:0] >= RSV_LO) && (ptr_q[LOC_W-1:0] <= RSV_HI);
    assign ptr_ctrl  = (ptr_q[LOC_W-1:0] == CTRL_LOC);

    function automatic logic [ADDR_W-1:0] next_ptr(input logic [ADDR_W-1:0] p);
        logic [LOC_W-1:0] loc, nloc;
        loc = p[LOC_W-1:0];
        if (loc <= CLK_TOP) nloc = (loc == CLK_TOP) ? '0 : loc + 1'b1;
        else                nloc = (loc == LOC_MAX) ? RAM_BASE : loc + 1'b1;
        return {p[ADDR_W-1], nloc};
    endfunction

    srif_rx_shift #(.W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .clear(state_q == ST_IDLE),
        .sample(cs_lvl && strobe_ev && (state_q == ST_ADDR || state_q == ST_WRITE)),
        .lsb_first(wire3_mode), .din(din_lvl),
        .data(rx_data), .done(rx_done)
    );

    srif_tx_shift #(.W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .clear(state_q != ST_READ),
        .load(fetch_pend_q),
        .load_data(ptr_rsv ? '0 : reg_rdata),
        .shift(cs_lvl && shift_ev && state_q == ST_READ),
        .lsb_first(wire3_mode),
        .bit_out(tx_bit), .last(tx_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_rise) state_d = ST_ADDR;
            ST_ADDR:  if (rx_done) state_d = rx_data[DATA_W-1] ? ST_WRITE : ST_READ;
            ST_WRITE: state_d = ST_WRITE;
            ST_READ:  state_d = ST_READ;
            default:  state_d = ST_IDLE;
        endcase
        if (!cs_lvl) state_d = ST_IDLE;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpol_q       <= 1'b0;
            wp_q         <= WP_RESET;
            dout_en_q    <= 1'b0;
            inc_pend_q   <= 1'b0;
            fetch_pend_q <= 1'b0;
            ptr_q        <= '0;
            reg_wr_en    <= 1'b0;
            reg_wdata    <= '0;
            reg_wmask    <= '0;
        end else begin
            reg_wr_en    <= 1'b0;
            inc_pend_q   <= 1'b0;
            fetch_pend_q <= 1'b0;
            if (state_q == ST_IDLE && cs_rise)
                cpol_q <= wire3_mode ? 1'b0 : sck_lvl;
            if (!cs_lvl) begin
                dout_en_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_ADDR: begin
                        if (rx_done) begin
                            ptr_q <= rx_data;
                            if (!rx_data[DATA_W-1]) fetch_pend_q <= 1'b1;
                        end
                    end
                    ST_WRITE: begin
                        if (rx_done) begin
                            reg_wdata  <= rx_data;
                            reg_wr_en  <= !ptr_rsv && (!wp_q || ptr_ctrl);
                            reg_wmask  <= (wp_q && ptr_ctrl) ? MASK_WP : MASK_ALL;
                            inc_pend_q <= 1'b1;
                            if (ptr_ctrl) wp_q <= rx_data[WP_BIT];
                        end
                        if (inc_pend_q) ptr_q <= next_ptr(ptr_q);
                    end
                    ST_READ: begin
                        if (shift_ev) dout_en_q <= 1'b1;
                        if (tx_last) begin
                            ptr_q        <= next_ptr(ptr_q);
                            fetch_pend_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign reg_addr    = ptr_q[LOC_W-1:0];
    assign reg_rd_en   = fetch_pend_q && !ptr_rsv;
    assign ser_dout    = tx_bit;
    assign ser_dout_en = dout_en_q;

    // ---------------- assertions ----------------
    p_wp_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr != CTRL_LOC) |-> !wp_q);
    p_wp_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wmask != MASK_ALL) |-> (reg_addr == CTRL_LOC && reg_wmask == MASK_WP));
    p_rsv_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> !(reg_addr >= RSV_LO && reg_addr <= RSV_HI));
    p_rsv_noread_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> !(reg_addr >= RSV_LO && reg_addr <= RSV_HI));
    p_hiz_cs_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_lvl |=> !ser_dout_en);
    p_dout_only_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_dout_en |-> state_q == ST_READ);
    p_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);
    p_no_dual_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));
    p_cpol_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(cpol_q));
endmodule

// File: tb/dual_serial_regport_tb_top.sv
module dual_serial_regport_tb_top;
    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       w3 = 1'b0, cs = 1'b0, sck = 1'b0, drv = 1'b0;
    logic       cur_idle = 1'b0;
    logic       ser_din, ser_dout, ser_dout_en;
    logic [6:0] reg_addr;
    logic       reg_wr_en, reg_rd_en;
    logic [7:0] reg_wdata, reg_wmask, reg_rdata;
    logic [7:0] mem [128];
    logic [6:0] log_a [64];
    logic [7:0] log_d [64];
    logic [7:0] log_m [64];
    int         log_n = 0;
    int         n_chk = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    assign ser_din   = (w3 && ser_dout_en) ? ser_dout : drv;
    assign reg_rdata = mem[reg_addr];

    dual_serial_regport dut_i (
        .clk(clk), .rst_n(rst_n), .wire3_mode(w3),
        .ser_cs(cs), .ser_sck(sck), .ser_din(ser_din),
        .ser_dout(ser_dout), .ser_dout_en(ser_dout_en),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_wmask(reg_wmask), .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] <= 8'(i * 7 + 3);
        end else if (reg_wr_en) begin
            mem[reg_addr] <= (mem[reg_addr] & ~reg_wmask) | (reg_wdata & reg_wmask);
            log_a[log_n] <= reg_addr;
            log_d[log_n] <= reg_wdata;
            log_m[log_n] <= reg_wmask;
            log_n <= log_n + 1;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic begin_x(bit m3, bit idle);
        w3 = m3; cur_idle = idle; sck = idle;
        tick(2 * H);
        cs = 1'b1;
        tick(2 * H);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 0; i < n; i++) begin
            drv = w3 ? b[i] : b[7 - i];
            tick(H);
            sck = ~cur_idle;
            tick(H);
            sck = cur_idle;
        end
    endtask

    task automatic recv_byte(output logic [7:0] b, output bit en_ok);
        logic v;
        en_ok = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(H);
            v = w3 ? ser_din : ser_dout;
            if (!ser_dout_en) en_ok = 1'b0;
            if (w3) b[i] = v; else b[7 - i] = v;
            sck = ~cur_idle;
            tick(H);
            sck = cur_idle;
        end
    endtask

    task automatic end_x;
        tick(H);
        cs = 1'b0;
        tick(3 * H);
    endtask

    task automatic wr1(logic [7:0] a, logic [7:0] d);
        begin_x(w3, cur_idle);
        send_bits(a, 8);
        send_bits(d, 8);
        end_x();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int lb;
        logic [7:0] got, base;
        bit en_ok;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // reset state
        chk(ser_dout_en == 1'b0, "R6", "reset dout_en", ser_dout_en, 0);
        chk(reg_wr_en == 1'b0, "R10", "reset wr_en", reg_wr_en, 0);

        // R7: protected after reset
        lb = log_n;
        wr1(8'h85, 8'h11);
        wr1(8'hA3, 8'h22);
        chk(log_n == lb, "R7", "writes while protected", log_n - lb, 0);
        lb = log_n;
        wr1(8'h8F, 8'h05);
        chk(log_n == lb + 1, "R7", "control write count", log_n - lb, 1);
        chk(log_a[lb] == 7'h0F && log_m[lb] == 8'h40, "R7", "control wp-only mask",
            {log_a[lb], log_m[lb]}, {7'h0F, 8'h40});
        lb = log_n;
        wr1(8'h85, 8'h11);
        chk(log_n == lb + 1 && log_a[lb] == 7'h05 && log_d[lb] == 8'h11 && log_m[lb] == 8'hFF,
            "R1", "unprotected write", {log_a[lb], log_d[lb]}, {7'h05, 8'h11});

        for (int m = 0; m < 3; m++) begin
            string rq;
            rq = (m == 2) ? "R3" : (m == 1) ? "R4" : "R2";
            base = 8'(8'h30 + m * 16);
            // RAM burst write with wrap FF->A0 (R5)
            lb = log_n;
            begin_x(m == 2, m == 1);
            send_bits(8'hFD, 8);
            for (int k = 0; k < 5; k++) send_bits(8'(base + k), 8);
            end_x();
            chk(log_n == lb + 5, "R5", "ram burst write count", log_n - lb, 5);
            for (int k = 0; k < 5; k++) begin
                logic [6:0] ea;
                ea = (k < 3) ? 7'(7'h7D + k) : 7'(7'h20 + k - 3);
                chk(log_a[lb + k] == ea && log_d[lb + k] == 8'(base + k) && log_m[lb + k] == 8'hFF,
                    rq, "burst write entry", {log_a[lb + k], log_d[lb + k]}, {ea, 8'(base + k)});
            end
            // RAM burst read with wrap 7F->20 (R5, R6)
            begin_x(m == 2, m == 1);
            send_bits(8'h7E, 8);
            chk(ser_dout_en == 1'b0, "R6", "hi-z after read address", ser_dout_en, 0);
            for (int k = 0; k < 4; k++) begin
                recv_byte(got, en_ok);
                chk(got == 8'(base + 1 + k), rq, "burst read byte", got, 8'(base + 1 + k));
                chk(en_ok, "R6", "dout_en during read", en_ok, 1);
            end
            end_x();
            chk(ser_dout_en == 1'b0, "R6", "hi-z after cs low", ser_dout_en, 0);
            // clock write wrap 9F->80, 9F reserved (R5, R8)
            lb = log_n;
            begin_x(m == 2, m == 1);
            send_bits(8'h9F, 8);
            send_bits(8'hEE, 8);
            send_bits(8'(base + 5), 8);
            end_x();
            chk(log_n == lb + 1, "R8", "reserved write skipped", log_n - lb, 1);
            chk(log_a[lb] == 7'h00 && log_d[lb] == 8'(base + 5), "R5", "clock write wrap",
                {log_a[lb], log_d[lb]}, {7'h00, 8'(base + 5)});
            // clock read wrap 1F->00 (R5, R8)
            begin_x(m == 2, m == 1);
            send_bits(8'h1E, 8);
            recv_byte(got, en_ok);
            chk(got == 8'h00, "R8", "reserved 1E reads zero", got, 0);
            recv_byte(got, en_ok);
            chk(got == 8'h00, "R8", "reserved 1F reads zero", got, 0);
            recv_byte(got, en_ok);
            chk(got == 8'(base + 5), "R5", "clock read wrap", got, 8'(base + 5));
            end_x();
            // abort a partial byte (R9)
            lb = log_n;
            begin_x(m == 2, m == 1);
            send_bits(8'hA5, 8);
            send_bits(8'(base + 6), 8);
            send_bits(8'hFF, 4);
            end_x();
            chk(log_n == lb + 1, "R9", "partial byte discarded", log_n - lb, 1);
            chk(log_a[lb] == 7'h25 && log_d[lb] == 8'(base + 6), "R10", "write addr/data",
                {log_a[lb], log_d[lb]}, {7'h25, 8'(base + 6)});
        end

        // re-protect (R7)
        w3 = 1'b0; cur_idle = 1'b0;
        lb = log_n;
        wr1(8'h8F, 8'h40);
        chk(log_n == lb + 1 && log_m[lb] == 8'hFF, "R7", "set wp full mask", log_m[lb], 8'hFF);
        lb = log_n;
        wr1(8'hA0, 8'h99);
        chk(log_n == lb, "R7", "ram write blocked", log_n - lb, 0);
        begin_x(1'b0, 1'b0);
        send_bits(8'h0F, 8);
        recv_byte(got, en_ok);
        end_x();
        chk(got == 8'h40, "R1", "control readback", got, 8'h40);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule